// File: doc/BRIEF.md
# Packed Ternary Weight Dot-Product Unit

This unit produces one element of a matrix-vector product whose weights are 2-bit codes, four to a byte. Each beat carries one packed weight byte and a 32-bit word with four signed 8-bit activations. Each code becomes a small signed factor in {0, +1, -1, -2}. That factor is applied by selection, negation and a one-place left shift, so the unit has no multiplier. The four lane terms of a beat are summed in a small adder tree, and the tree output is added into a signed accumulator.

A row begins with a one-cycle start pulse that carries the number of weight bytes in the row. Beats are accepted on a valid/ready handshake while the row is open. One cycle after the final beat is accepted, a one-cycle done pulse is raised and the result output holds the finished sum. The result stays unchanged until the next row begins. Normalisation, quantisation, dequantisation scaling and weight storage are handled elsewhere.

Top module: `tdot_unit`

## Requirements
- R1: Lane k of a beat takes its code from w_byte[2k+1:2k] and pairs it with the activation at act_word[8k+7:8k], for k = 0..3.
- R2: The code values map to factors as follows: 2'b00 gives 0, 2'b01 gives +1, 2'b10 gives -1 and 2'b11 gives -2.
- R3: Activations are two's-complement signed 8-bit values. The extremes are exact: -128 with code 2'b11 contributes +256.
- R4: When the unit is idle, a start pulse with byte_count = N > 0 clears the accumulator and raises in_ready. in_ready stays high until N beats have been accepted. A cycle with in_valid low is not counted.
- R5: One cycle after the N-th beat is accepted, done is high for exactly one cycle and result equals the sum over all beats of the lane factor times the lane activation.
- R6: The accumulator wraps in two's complement at ACC_W bits and does not saturate.
- R7: A start pulse with byte_count = 0 gives a done pulse on the next cycle with result 0.
- R8: When idle, in_ready is low and data beats have no effect. A start pulse that arrives while a row is open is ignored.
- R9: A synchronous active-high reset drives in_ready, done and result to 0.
- R10: result holds its value from the done pulse until the cycle after the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a row when the unit is idle |
| byte_count | input | CNT_W (16) | Number of weight bytes in the row, sampled with start |
| in_valid | input | 1 | Beat data is present |
| in_ready | output | 1 | High while a row is open and beats are being accepted |
| w_byte | input | LANES*2 (8) | Four packed 2-bit weight codes |
| act_word | input | LANES*ACT_W (32) | Four signed activations, lane k in bits [8k+7:8k] |
| done | output | 1 | One-cycle pulse when the row is complete |
| result | output | ACC_W (32) | Accumulated signed sum |

## Verification
The assertions take three things for granted. Start and beat data are driven in the same clock domain, byte_count fits in CNT_W bits, and nothing other than start or an accepted beat changes the accumulator. They only check handshake and timing relations: done is a single-cycle pulse, ready opens after a non-empty start, an empty row completes at once, and result is stable while idle. The stimulus changes every input at the falling edge, so the unit always samples settled values. It inserts idle and invalid cycles, a start pulse during an open row, and a second narrow-accumulator instance so that wrap-around can be reached within a short run.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

   // 2-bit weight code and the factor it selects
   typedef enum logic [1:0] {
      WC_ZERO = 2'b00,   // factor  0
      WC_POS  = 2'b01,   // factor +1
      WC_NEG  = 2'b10,   // factor -1
      WC_NEG2 = 2'b11    // factor -2
   } wcode_e;

   localparam int CODE_W = 2;

endpackage

// File: rtl/tdot_lane.sv
// One lane: turns a weight code and a signed activation into a term
// using only select, negate and a one-place shift.
module tdot_lane
   import tdot_pkg::*;
#(
   parameter int ACT_W  = 8,
   parameter int TERM_W = ACT_W + 2
) (
   input  logic [CODE_W-1:0]        code,
   input  logic [ACT_W-1:0]         act,
   output logic signed [TERM_W-1:0] term
);

   logic signed [TERM_W-1:0] ext;
   logic signed [TERM_W-1:0] neg;
   logic signed [TERM_W-1:0] neg_dbl;

   always_comb begin
      ext     = {{(TERM_W-ACT_W){act[ACT_W-1]}}, act};
      neg     = -ext;
      neg_dbl = neg <<< 1;
      unique case (wcode_e'(code))
         WC_ZERO: term = '0;
         WC_POS:  term = ext;
         WC_NEG:  term = neg;
         WC_NEG2: term = neg_dbl;
         default: term = '0;
      endcase
   end

endmodule

// File: rtl/tdot_tree.sv
// Balanced adder tree summing LANES signed terms.
module tdot_tree #(
   parameter int LANES  = 4,
   parameter int TERM_W = 10,
   parameter int SUM_W  = TERM_W + ((LANES > 1) ? $clog2(LANES) : 0)
) (
   input  logic [LANES*TERM_W-1:0] terms,
   output logic signed [SUM_W-1:0] sum
);

   generate
      if (LANES == 1) begin : g_single
         always_comb sum = SUM_W'($signed(terms[TERM_W-1:0]));
      end else begin : g_heap
         localparam int NODES = 2*LANES - 1;
         logic signed [SUM_W-1:0] node [NODES];

         always_comb begin
            for (int k = 0; k < LANES; k++) begin
               node[LANES-1+k] = SUM_W'($signed(terms[k*TERM_W +: TERM_W]));
            end
            for (int i = LANES-2; i >= 0; i--) begin
               node[i] = node[2*i+1] + node[2*i+2];
            end
            sum = node[0];
         end
      end
   endgenerate

endmodule

// File: rtl/tdot_ctrl.sv
// Row sequencing: beat counter, handshake and completion pulse.
module tdot_ctrl #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CNT_W-1:0] byte_count,
   input  logic             in_valid,
   output logic             busy,
   output logic             launch,
   output logic             accept,
   output logic             done
);

   logic             busy_q;
   logic [CNT_W-1:0] left_q;
   logic             done_q;
   logic             final_beat;

   assign busy       = busy_q;
   assign launch     = start & ~busy_q;
   assign accept     = busy_q & in_valid;
   assign final_beat = accept & (left_q == CNT_W'(1));
   assign done       = done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         left_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (launch) begin
            if (byte_count == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q <= 1'b1;
               left_q <= byte_count;
            end
         end else if (accept) begin
            left_q <= left_q - CNT_W'(1);
            if (final_beat) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/tdot_accum.sv
// Wrapping signed accumulator.
module tdot_accum #(
   parameter int ACC_W = 32,
   parameter int SUM_W = 12
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    clear,
   input  logic                    add_en,
   input  logic signed [SUM_W-1:0] addend,
   output logic [ACC_W-1:0]        acc
);

   logic [ACC_W-1:0] addend_ext;

   generate
      if (ACC_W > SUM_W) begin : g_widen
         assign addend_ext = {{(ACC_W-SUM_W){addend[SUM_W-1]}}, addend};
      end else begin : g_same
         assign addend_ext = addend;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)         acc <= '0;
      else if (clear)  acc <= '0;
      else if (add_en) acc <= acc + addend_ext;
   end

endmodule

// File: rtl/tdot_unit.sv
// Packed ternary weight dot-product unit (top).
module tdot_unit
   import tdot_pkg::*;
#(
   parameter int LANES = 4,
   parameter int ACT_W = 8,
   parameter int ACC_W = 32,
   parameter int CNT_W = 16
) (
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   start,
   input  logic [CNT_W-1:0]       byte_count,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [LANES*CODE_W-1:0] w_byte,
   input  logic [LANES*ACT_W-1:0] act_word,
   output logic                   done,
   output logic [ACC_W-1:0]       result
);

   localparam int TERM_W = ACT_W + 2;
   localparam int SUM_W  = TERM_W + ((LANES > 1) ? $clog2(LANES) : 0);

   generate
      if (LANES < 1 || (LANES & (LANES-1)) != 0) begin : g_bad_lanes
         $error("tdot_unit: LANES must be a power of two");
      end
      if (ACT_W < 2) begin : g_bad_act
         $error("tdot_unit: ACT_W must be at least 2");
      end
      if (ACC_W < SUM_W) begin : g_bad_acc
         $error("tdot_unit: ACC_W must hold one beat sum");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("tdot_unit: CNT_W must be positive");
      end
   endgenerate

   logic                    busy;
   logic                    launch;
   logic                    accept;
   logic [LANES*TERM_W-1:0] terms;
   logic signed [SUM_W-1:0] beat_sum;

   tdot_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .byte_count (byte_count),
      .in_valid   (in_valid),
      .busy       (busy),
      .launch     (launch),
      .accept     (accept),
      .done       (done)
   );

   assign in_ready = busy;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         logic signed [TERM_W-1:0] t;
         tdot_lane #(.ACT_W(ACT_W), .TERM_W(TERM_W)) u_lane (
            .code (w_byte[k*CODE_W +: CODE_W]),
            .act  (act_word[k*ACT_W +: ACT_W]),
            .term (t)
         );
         assign terms[k*TERM_W +: TERM_W] = t;
      end
   endgenerate

   tdot_tree #(.LANES(LANES), .TERM_W(TERM_W), .SUM_W(SUM_W)) u_tree (
      .terms (terms),
      .sum   (beat_sum)
   );

   tdot_accum #(.ACC_W(ACC_W), .SUM_W(SUM_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .clear  (launch),
      .add_en (accept),
      .addend (beat_sum),
      .acc    (result)
   );

endmodule

// File: rtl/tdot_chk.sv
// Protocol checker attached to every tdot_unit instance.
module tdot_chk #(
   parameter int ACC_W = 32,
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             start,
   input logic [CNT_W-1:0] byte_count,
   input logic             in_ready,
   input logic             done,
   input logic [ACC_W-1:0] result
);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R4
   open_row_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !in_ready && byte_count != '0) |=> in_ready);

   // R7
   empty_row_chk: assert property (@(posedge clk) disable iff (rst)
      (start && !in_ready && byte_count == '0) |=> (done && result == '0));

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> !in_ready);

   // R10
   hold_result_chk: assert property (@(posedge clk) disable iff (rst)
      (!in_ready && !start) |=> $stable(result));

   // R9
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (!in_ready && !done && result == '0));

endmodule

bind tdot_unit tdot_chk #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .start      (start),
   .byte_count (byte_count),
   .in_ready   (in_ready),
   .done       (done),
   .result     (result)
);

// File: tb/tdot_unit_bench.sv
module tdot_unit_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] byte_count = '0;
   logic        in_valid = 1'b0;
   logic [7:0]  w_byte = '0;
   logic [31:0] act_word = '0;
   logic        in_ready, done, in_ready_n, done_n;
   logic [31:0] result;
   logic [11:0] result_n;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0]  rb [16];
   logic [31:0] ra [16];

   always #5 clk = ~clk;

   tdot_unit u_tdot_unit (
      .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
      .in_valid(in_valid), .in_ready(in_ready), .w_byte(w_byte),
      .act_word(act_word), .done(done), .result(result)
   );

   // narrow accumulator copy so wrap-around is reachable (R6)
   tdot_unit #(.ACC_W(12)) u_narrow (
      .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
      .in_valid(in_valid), .in_ready(in_ready_n), .w_byte(w_byte),
      .act_word(act_word), .done(done_n), .result(result_n)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int beat_val(logic [7:0] b, logic [31:0] a);
      int s = 0;
      for (int k = 0; k < 4; k++) begin
         int av;
         av = int'($signed(a[8*k +: 8]));
         case (b[2*k +: 2])
            2'b00: s += 0;
            2'b01: s += av;
            2'b10: s -= av;
            default: s -= 2*av;
         endcase
      end
      return s;
   endfunction

   // runs a row of n beats from rb/ra; gap inserts an invalid cycle
   task automatic run_row(string req, int n, bit gap);
      int exp = 0;
      logic [11:0] exp_n;
      @(negedge clk);
      start = 1'b1; byte_count = 16'(n);
      @(negedge clk);
      start = 1'b0; byte_count = 16'hBEEF;
      for (int i = 0; i < n; i++) begin
         if (gap && i > 0) begin
            in_valid = 1'b0; w_byte = 8'hFF; act_word = 32'h7F7F7F7F;
            @(negedge clk);
         end
         in_valid = 1'b1; w_byte = rb[i]; act_word = ra[i];
         exp += beat_val(rb[i], ra[i]);
         @(negedge clk);
      end
      in_valid = 1'b0;
      exp_n = exp[11:0];
      check({req, " R5 done"}, 32'(done), 32'd1);
      check({req, " R5 result"}, result, exp);
      check({req, " R6 narrow"}, 32'(result_n), 32'(exp_n));
      check({req, " R4 ready closed"}, 32'(in_ready), 32'd0);
   endtask

   task automatic t_reset();
      check("R9 ready", 32'(in_ready), 32'd0);
      check("R9 done", 32'(done), 32'd0);
      check("R9 result", result, 32'd0);
   endtask

   task automatic t_lanes();
      // R1: only lane k has code +1; lanes hold distinct activations
      for (int k = 0; k < 4; k++) begin
         rb[0] = 8'(2'b01 << (2*k));
         ra[0] = 32'hF1_2C_09_05;
         run_row($sformatf("R1 lane%0d", k), 1, 1'b0);
      end
   endtask

   task automatic t_codes();
      // R2: each code on the same activation value 10
      rb[0] = 8'b11_10_01_00; ra[0] = 32'h0A0A0A0A;   // 0+10-10-20 = -20
      rb[1] = 8'b01_01_11_10; ra[1] = 32'h03_05_07_FE; // 2 -14 +5 +3 = -4
      run_row("R2 codes", 2, 1'b0);
      check("R2 value", result, 32'hFFFF_FFE8);
   endtask

   task automatic t_extremes();
      rb[0] = 8'hFF; ra[0] = 32'h80808080;   // 4*256
      rb[1] = 8'hAA; ra[1] = 32'h7F7F7F7F;   // -4*127
      rb[2] = 8'h55; ra[2] = 32'h80_7F_80_7F;
      run_row("R3 extremes", 3, 1'b0);
   endtask

   task automatic t_long_gaps();
      for (int i = 0; i < 12; i++) begin
         rb[i] = 8'(i*37 + 11);
         ra[i] = 32'(32'h9E3779B9 * (i+1));
      end
      run_row("R4 gaps", 12, 1'b1);
   endtask

   task automatic t_empty();
      rb[0] = 8'h55; ra[0] = 32'h01010101;
      run_row("R7 pre", 1, 1'b0);
      run_row("R7 empty", 0, 1'b0);
   endtask

   task automatic t_idle_ignored();
      logic [31:0] held;
      held = result;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         in_valid = 1'b1; w_byte = 8'h55; act_word = 32'h11111111;
      end
      @(negedge clk);
      check("R8 idle ready", 32'(in_ready), 32'd0);
      check("R8 idle done", 32'(done), 32'd0);
      check("R10 held", result, held);
      in_valid = 1'b0;
   endtask

   task automatic t_start_busy();
      int exp;
      @(negedge clk);
      start = 1'b1; byte_count = 16'd2;
      @(negedge clk);
      start = 1'b0;
      in_valid = 1'b1; w_byte = 8'h01; act_word = 32'h00000023; // +35
      @(negedge clk);
      in_valid = 1'b0; start = 1'b1; byte_count = 16'd7;
      @(negedge clk);
      start = 1'b0;
      check("R8 still open", 32'(in_ready), 32'd1);
      in_valid = 1'b1; w_byte = 8'h02; act_word = 32'h00000005; // -5
      @(negedge clk);
      in_valid = 1'b0;
      exp = 30;
      check("R8 busy start done", 32'(done), 32'd1);
      check("R8 busy start sum", result, exp);
   endtask

   task automatic t_wrap();
      for (int i = 0; i < 3; i++) begin
         rb[i] = 8'hFF; ra[i] = 32'h80808080;
      end
      run_row("R6 wrap", 3, 1'b0);
      check("R6 narrow value", 32'(result_n), 32'hC00);  // -1024 in 12 bits
   endtask

   task automatic t_clear();
      // R4: a fresh row starts from zero
      rb[0] = 8'h01; ra[0] = 32'h00000003;
      run_row("R4 clear", 1, 1'b0);
      check("R4 fresh sum", result, 32'd3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_lanes();
      t_codes();
      t_extremes();
      t_long_gaps();
      t_empty();
      t_idle_ignored();
      t_start_busy();
      t_wrap();
      t_clear();
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule